// File: doc/BRIEF.md
# Tagged Line Response Sequencer

This block drives the reply side of a bus that splits each transaction into a request and a later response. A producer hands it one 128-byte cache line and the 3-bit tag of the request that line answers. When the bus arbiter grants it the response bus, it sends the line as four consecutive 256-bit beats. The tag goes out on a separate tag bus with every beat, so the address bus stays free and replies can finish in any order. After the fourth beat the sequencer always leaves one turnaround cycle with nothing driven. During that cycle it may take the next line, so a busy responder repeats a five-cycle pattern of four beats and one gap.

The controller has three named states. `ST_IDLE` means no transfer is under way. `ST_BEAT` means a beat is on the bus, and a beat index counts 0 to 3. `ST_GAP` is the turnaround cycle. There are five transitions. IDLE→BEAT and GAP→BEAT happen on a take, which is `in_valid` and `in_ready` high together. BEAT→BEAT moves to the next beat index. BEAT→GAP follows the last beat. GAP→IDLE happens when nothing is taken during the gap. `in_ready` is the grant gated by "not in BEAT", so the grant is looked at only in IDLE and GAP. Once a transfer has started it cannot be stopped.

Top module: `rsp_seq`

## Requirements
- R1: After reset, `out_valid` is 0, `out_data` and `out_tag` are 0, and `in_ready` equals `grant`.
- R2: When not in a transfer, `in_ready` equals `grant`. A line and tag are taken in a cycle where `in_valid` and `in_ready` are both 1.
- R3: In the cycle after a take, `out_valid` rises and stays 1 for exactly four consecutive cycles.
- R4: Beat k (k = 0..3) carries `in_line[256k+255 : 256k]`, so the lowest-addressed 32 bytes go first.
- R5: `out_tag` equals the tag that was taken and holds steady for all four beats.
- R6: The cycle after the fourth beat is a turnaround cycle in which `out_valid`, `out_data` and `out_tag` are all 0.
- R7: During the four beats `in_ready` is 0. Changes on `grant`, `in_valid`, `in_line` or `in_tag` do not alter or cut short the transfer.
- R8: A take during the turnaround cycle starts the next transfer's beat 0 in the very next cycle, giving a five-cycle repeat.
- R9: While `grant` is 0, nothing is taken and `out_valid` stays 0. A line offered across such cycles is sent unchanged once grant arrives.
- R10: Any tag value 0..7 passes through, and successive replies may carry tags in any order.
- R11: Whenever `out_valid` is 0, `out_data` and `out_tag` are driven to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A line and tag are offered |
| in_ready | output | 1 | The offered line is taken this cycle if valid |
| in_line | input | 1024 | Cache line, byte 0 in bits 7:0 |
| in_tag | input | 3 | Tag of the request being answered |
| grant | input | 1 | Response bus granted to this sequencer |
| out_valid | output | 1 | A data beat is on the bus |
| out_data | output | 256 | Data beat |
| out_tag | output | 3 | Tag that goes with the current beat |

## Verification
The hardest case to reach is a take during the turnaround cycle. It needs `in_valid` and `grant` to be high exactly one cycle after the fourth beat, which is the only point where the gap can be used again. The bench chains transfers by having each scenario task return while the sequencer sits in the gap cycle. The next task then drives its line at once, and the bench checks the spacing between first beats. A separate task drops the grant and changes every input while the beats are on the bus, to show that a transfer cannot be cut short.

// File: rtl/rsp_seq_pkg.sv
package rsp_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BEAT = 2'd1,
        ST_GAP  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/rsp_seq_ctrl.sv
module rsp_seq_ctrl
    import rsp_seq_pkg::*;
#(
    parameter int BEATS = 4,
    localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             grant,
    output logic             in_ready,
    output logic             load,
    output logic             beat_on,
    output logic [IDX_W-1:0] beat_idx
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BEATS - 1);

    seq_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             take;

    assign take = in_valid && in_ready;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_GAP: state_d = take ? ST_BEAT : ST_IDLE;
            ST_BEAT:         state_d = (idx_q == LAST_IDX) ? ST_GAP : ST_BEAT;
            default:         state_d = ST_IDLE;
        endcase
    end

    // state register and beat counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (take)
                idx_q <= '0;
            else if (state_q == ST_BEAT)
                idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        in_ready = 1'b0;
        beat_on  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_GAP: in_ready = grant;
            ST_BEAT:         beat_on  = 1'b1;
            default:         in_ready = 1'b0;
        endcase
        load     = take;
        beat_idx = idx_q;
    end

    assert_take_starts_beats_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (state_q == ST_BEAT) && (idx_q == '0));

    assert_beats_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BEAT) && (idx_q != LAST_IDX) |=> (state_q == ST_BEAT) && (idx_q == $past(idx_q) + 1'b1));

    assert_gap_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BEAT) && (idx_q == LAST_IDX) |=> (state_q == ST_GAP));

    assert_gap_reuse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP) && take |=> (state_q == ST_BEAT) && (idx_q == '0));

endmodule

// File: rtl/rsp_seq_hold.sv
module rsp_seq_hold #(
    parameter int LINE_W = 1024,
    parameter int TAG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              busy,
    input  logic [LINE_W-1:0] line_in,
    input  logic [TAG_W-1:0]  tag_in,
    output logic [LINE_W-1:0] line_q,
    output logic [TAG_W-1:0]  tag_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            tag_q  <= '0;
        end else if (load) begin
            line_q <= line_in;
            tag_q  <= tag_in;
        end
    end

    assert_no_reload_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !load);

    assert_held_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(tag_q) && $stable(line_q));

endmodule

// File: rtl/rsp_seq_mux.sv
module rsp_seq_mux #(
    parameter int BUS_W = 256,
    parameter int BEATS = 4,
    parameter int TAG_W = 3,
    localparam int LINE_W = BUS_W * BEATS,
    localparam int IDX_W  = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic [LINE_W-1:0] line,
    input  logic [TAG_W-1:0]  tag,
    input  logic              on,
    input  logic [IDX_W-1:0]  idx,
    output logic              out_valid,
    output logic [BUS_W-1:0]  out_data,
    output logic [TAG_W-1:0]  out_tag
);

    logic [BUS_W-1:0] slice [BEATS];

    for (genvar g = 0; g < BEATS; g++) begin : g_slice
        assign slice[g] = line[g*BUS_W +: BUS_W];
    end

    always_comb begin
        out_valid = on;
        out_data  = on ? slice[idx] : '0;
        out_tag   = on ? tag : '0;
    end

endmodule

// File: rtl/rsp_seq.sv
module rsp_seq #(
    parameter int LINE_BYTES = 128,
    parameter int BUS_W      = 256,
    parameter int TAG_W      = 3,
    localparam int LINE_W = LINE_BYTES * 8,
    localparam int BEATS  = LINE_W / BUS_W,
    localparam int IDX_W  = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [LINE_W-1:0] in_line,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic              grant,
    output logic              out_valid,
    output logic [BUS_W-1:0]  out_data,
    output logic [TAG_W-1:0]  out_tag
);

    logic              load;
    logic              beat_on;
    logic [IDX_W-1:0]  beat_idx;
    logic [LINE_W-1:0] line_q;
    logic [TAG_W-1:0]  tag_q;

    rsp_seq_ctrl #(.BEATS(BEATS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .grant    (grant),
        .in_ready (in_ready),
        .load     (load),
        .beat_on  (beat_on),
        .beat_idx (beat_idx)
    );

    rsp_seq_hold #(.LINE_W(LINE_W), .TAG_W(TAG_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .busy    (beat_on),
        .line_in (in_line),
        .tag_in  (in_tag),
        .line_q  (line_q),
        .tag_q   (tag_q)
    );

    rsp_seq_mux #(.BUS_W(BUS_W), .BEATS(BEATS), .TAG_W(TAG_W)) u_mux (
        .line      (line_q),
        .tag       (tag_q),
        .on        (beat_on),
        .idx       (beat_idx),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_tag   (out_tag)
    );

    assert_ready_low_in_beats_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    assert_valid_after_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    assert_tag_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(out_valid) |-> $stable(out_tag));

    assert_no_grant_no_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid && !grant |=> !out_valid);

endmodule

// File: tb/rsp_seq_bench.sv
module rsp_seq_bench;

    localparam int LW = 1024;
    localparam int BW = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [LW-1:0] in_line = '0;
    logic [2:0]    in_tag = '0;
    logic          grant = 1'b0;
    logic          out_valid;
    logic [BW-1:0] out_data;
    logic [2:0]    out_tag;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int last_start = 0;
    int this_start = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rsp_seq u_rsp_seq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_line(in_line), .in_tag(in_tag), .grant(grant),
        .out_valid(out_valid), .out_data(out_data), .out_tag(out_tag)
    );

    task automatic chk(input bit ok, input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [LW-1:0] mk_line(input logic [7:0] s);
        logic [LW-1:0] l;
        for (int i = 0; i < 32; i++)
            l[i*32 +: 32] = {s, 8'(i), ~s, 8'(i * 3 + 1)};
        return l;
    endfunction

    // Caller stands at a negedge with the sequencer in idle or gap.
    // Returns at the negedge of the gap cycle.
    task automatic run_line(input logic [LW-1:0] l, input logic [2:0] t, input bit scramble);
        in_valid = 1'b1; grant = 1'b1; in_line = l; in_tag = t;
        #1;
        chk(in_ready == 1'b1, "R2 ready with grant", BW'(in_ready), 1);
        @(negedge clk);
        this_start = cyc;
        for (int b = 0; b < 4; b++) begin
            if (scramble) begin
                in_valid = 1'b1; grant = b[0]; in_line = ~l; in_tag = ~t;
            end else begin
                in_valid = 1'b0; grant = 1'b0;
            end
            #1;
            chk(out_valid == 1'b1, "R3 valid on beat", BW'(out_valid), 1);
            chk(out_data == l[b*BW +: BW], "R4 beat data order", out_data, l[b*BW +: BW]);
            chk(out_tag == t, "R5 R10 tag on beat", BW'(out_tag), BW'(t));
            chk(in_ready == 1'b0, "R7 ready low in beats", BW'(in_ready), 0);
            @(negedge clk);
        end
        in_valid = 1'b0; grant = 1'b0;
        #1;
        chk(out_valid == 1'b0, "R6 gap valid low", BW'(out_valid), 0);
        chk(out_data == '0 && out_tag == '0, "R6 R11 gap bus quiet", out_data | BW'(out_tag), 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; in_valid = 1'b0; grant = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid after reset", BW'(out_valid), 0);
        chk(out_data == '0 && out_tag == '0, "R1 bus zero after reset", out_data | BW'(out_tag), 0);
        grant = 1'b1; #1;
        chk(in_ready == 1'b1, "R1 ready follows grant", BW'(in_ready), 1);
        grant = 1'b0; #1;
        chk(in_ready == 1'b0, "R1 ready follows grant low", BW'(in_ready), 0);
        @(negedge clk);
    endtask

    task automatic t_single;
        run_line(mk_line(8'h11), 3'd5, 1'b0);
        @(negedge clk);
        chk(out_valid == 1'b0, "R11 idle after gap", BW'(out_valid), 0);
    endtask

    task automatic t_no_grant;
        logic [LW-1:0] l = mk_line(8'h5a);
        in_valid = 1'b1; grant = 1'b0; in_line = l; in_tag = 3'd6;
        for (int i = 0; i < 3; i++) begin
            #1;
            chk(in_ready == 1'b0, "R9 not ready without grant", BW'(in_ready), 0);
            @(negedge clk);
            chk(out_valid == 1'b0, "R9 no beat without grant", BW'(out_valid), 0);
        end
        in_valid = 1'b0; grant = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R2 grant without valid takes nothing", BW'(out_valid), 0);
        run_line(l, 3'd6, 1'b0);
        @(negedge clk);
    endtask

    task automatic t_no_abort;
        run_line(mk_line(8'hc3), 3'd1, 1'b1);
        @(negedge clk);
    endtask

    task automatic t_back_to_back;
        run_line(mk_line(8'h21), 3'd7, 1'b0);
        last_start = this_start;
        run_line(mk_line(8'h42), 3'd2, 1'b0);
        chk(this_start - last_start == 5, "R8 five cycle repeat", BW'(this_start - last_start), 5);
        last_start = this_start;
        run_line(mk_line(8'h84), 3'd0, 1'b0);
        chk(this_start - last_start == 5, "R8 five cycle repeat", BW'(this_start - last_start), 5);
        last_start = this_start;
        run_line(mk_line(8'h99), 3'd4, 1'b0);
        chk(this_start - last_start == 5, "R8 R10 five cycle repeat", BW'(this_start - last_start), 5);
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_single();
        t_no_grant();
        t_no_abort();
        t_back_to_back();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule